// File: doc/BRIEF.md
# Configurable SPI Byte Engine

This block moves one byte at a time over a four-wire SPI link, as either the clock-driving master or a clocked slave. One 8-bit control word selects the role, the clock polarity and phase, the bit order, a master clock divisor and a divisor-halving boost, and it holds a global enable. A small register port reaches that control word and a data register. A write to the data register loads the outgoing byte. A read returns the last byte received and clears the completion flag.

In master mode, a data write while the engine is idle starts eight SCK cycles at the selected rate. In slave mode, the engine follows an external SCK while SS is held low. It drives MISO only during that time. If SS is pulled low while the engine is enabled as master, the master bit clears itself and the engine carries on as a slave.

Control flows through four states. `ST_IDLE` is the resting state. `ST_M_FIRST` is the first half of a master bit, with SCK at its idle level; its tick makes the leading edge. `ST_M_SECOND` is the second half of a master bit; its tick makes the trailing edge. `ST_S_ACTIVE` means a slave is selected. The transitions are:
- start: `ST_IDLE` to `ST_M_FIRST`, on a data write while the engine is enabled master.
- lead: `ST_M_FIRST` to `ST_M_SECOND`, on a divider tick.
- next: `ST_M_SECOND` to `ST_M_FIRST`, on a tick before the last bit.
- finish: `ST_M_SECOND` to `ST_IDLE`, on the tick of the last bit.
- select: `ST_IDLE` to `ST_S_ACTIVE`, when SS goes low with the engine enabled as slave.
- release: `ST_S_ACTIVE` to `ST_IDLE`, when SS goes high or the engine is disabled.
- abort: either master state to `ST_IDLE`, on a mode fault or when the engine is disabled.

Top module: `spi_engine`

## Requirements
- R1: After reset, the control word reads 0x00, the done flag is 0, `miso_oe` is 0 and `sck_o` is 0.
- R2: The control word (address 0) reads back what was written. Its fields are: bit 7 rate boost, bit 6 enable, bit 5 LSB-first, bit 4 master, bits 3:2 mode, bits 1:0 rate code.
- R3: While the enable bit is 0, a data write causes no SCK edge, and the done flag never rises.
- R4: With the LSB-first bit at 1, bit 0 travels first on both data lines; with it at 0, bit 7 travels first.
- R5: In master mode, SCK rests low when mode bit 3 is 0 and rests high when mode bit 3 is 1, both before and after a transfer.
- R6: With mode bit 2 at 0, data is sampled on the leading SCK edge and changed on the trailing edge. With mode bit 2 at 1, data is changed on the leading edge and sampled on the trailing edge.
- R7: In master mode, a data write (address 1) while idle produces exactly 16 SCK edges. A data write during a transfer is ignored.
- R8: With the rate boost bit at 0, rate codes 0, 1, 2 and 3 give SCK half-periods of 2, 8, 32 and 64 system clocks.
- R9: With the rate boost bit at 1, rate codes 0, 1, 2 and 3 give half-periods of 1, 4, 16 and 32 system clocks.
- R10: The done flag rises after the eighth sample edge. A read of address 1 clears it.
- R11: If SS is low while the enable and master bits are 1, the master bit clears within 4 cycles, the enable bit stays 1, and the engine acts as a slave.
- R12: In slave mode, `miso_oe` is 0 while SS is high. A transfer cut short by SS going high is discarded, so the next full byte is received and sent intact.
- R13: In slave mode, in all four modes and with SCK half-periods of at least 4 system clocks, the byte on MOSI is received and the loaded byte appears on MISO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 1 clears the flag) |
| reg_addr | input | 1 | 0 = control word, 1 = data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| done_flag | output | 1 | Byte-complete flag |
| sck_i | input | 1 | SCK from the external master (slave mode) |
| sck_o | output | 1 | SCK driven in master mode |
| mosi_i | input | 1 | MOSI input (slave mode) |
| mosi_o | output | 1 | MOSI output (master mode) |
| miso_i | input | 1 | MISO input (master mode) |
| miso_o | output | 1 | MISO output (slave mode) |
| miso_oe | output | 1 | MISO output enable |
| ss_n_i | input | 1 | Active-low slave select input |

## Verification
The assertions take four things for granted about the inputs:
- During a master transfer, SS stays high, except in the deliberate mode-fault scenario.
- In master mode, `miso_i` is steady at every sample edge, since the master samples it without synchronization.
- An external SCK half-period is never shorter than the three-stage path through the synchronizer.
- The control word is not rewritten while a byte is in flight.

The bench keeps to these limits. It changes `miso_i` only just after a setup edge it has observed. It drives slave SCK with a half-period of 4 system clocks. It holds SS high during every master run, and it writes the control word only between transfers.

// File: rtl/spi_pkg.sv
package spi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_M_FIRST,
        ST_M_SECOND,
        ST_S_ACTIVE
    } spi_state_t;

    typedef struct packed {
        logic       boost;
        logic       en;
        logic       lsb_first;
        logic       master;
        logic [1:0] mode;
        logic [1:0] rate;
    } spi_ctrl_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int           W   = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST;
            q      <= RST;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    input  logic       boost,
    output logic       tick
);
    logic [2:0]       half_log;
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] cnt_q;

    // exponent of the half-period for each rate code, boost lowers it by one
    always_comb begin
        unique case (rate)
            2'd0: half_log = 3'd1;
            2'd1: half_log = 3'd3;
            2'd2: half_log = 3'd5;
            2'd3: half_log = 3'd6;
        endcase
        half_m1 = (CNT_W'(1) << (half_log - 3'(boost))) - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!run)             cnt_q <= '0;
        else if (cnt_q >= half_m1) cnt_q <= '0;
        else                       cnt_q <= cnt_q + CNT_W'(1);
    end

    assign tick = run && (cnt_q >= half_m1);

    // R8: a half-period longer than one cycle never yields back-to-back ticks
    assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && half_m1 != '0 && $stable(rate) && $stable(boost)) |=> !tick);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         lsb_first,
    input  logic         shift,
    input  logic         sample,
    input  logic         din,
    output logic         dout,
    output logic [W-1:0] rx_next
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     tx_q <= '0;
        else if (load)  tx_q <= load_val;
        else if (shift) tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
    end

    always_comb begin
        rx_next = rx_q;
        if (sample)
            rx_next = lsb_first ? {din, rx_q[W-1:1]} : {rx_q[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_next;
    end

    assign dout = lsb_first ? tx_q[0] : tx_q[W-1];
endmodule

// File: rtl/spi_engine.sv
module spi_engine
    import spi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              done_flag,
    input  logic              sck_i,
    output logic              sck_o,
    input  logic              mosi_i,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i
);
    localparam int CW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    spi_ctrl_t   ctrl_q;
    spi_state_t  state_q, state_d;
    logic [2:0]  sync_q;
    logic        ss_s, sck_s, mosi_s, sck_prev_q;
    logic        cpol, cpha, is_master, is_slave, mfault;
    logic        wr_ctrl, wr_data, rd_data;
    logic        tick, m_run;
    logic        m_lead, m_trail, s_edge, s_lead, s_trail;
    logic        lead_ev, trail_ev, sample_ev, setup_ev, do_shift, flag_set;
    logic        load_tx, tx_bit, din;
    logic [CW-1:0]     bit_cnt_q, nsamp_q;
    logic              sck_q;
    logic [DATA_W-1:0] rx_next, rx_buf_q;

    // ---------------- input synchronizer (slave side and select) ----------
    spi_sync #(.W(3), .RST(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_i, sck_i, mosi_i}),
        .q     (sync_q)
    );
    assign ss_s   = sync_q[2];
    assign sck_s  = sync_q[1];
    assign mosi_s = sync_q[0];

    // ---------------- decode ----------------------------------------------
    assign cpol      = ctrl_q.mode[1];
    assign cpha      = ctrl_q.mode[0];
    assign is_master = ctrl_q.en && ctrl_q.master;
    assign is_slave  = ctrl_q.en && !ctrl_q.master;
    assign mfault    = is_master && !ss_s;
    assign wr_ctrl   = reg_wr && !reg_addr;
    assign wr_data   = reg_wr && reg_addr;
    assign rd_data   = reg_rd && reg_addr;

    // ---------------- master clock divider --------------------------------
    assign m_run = (state_q == ST_M_FIRST) || (state_q == ST_M_SECOND);

    spi_clkgen #(.CNT_W(CNT_W)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (m_run),
        .rate  (ctrl_q.rate),
        .boost (ctrl_q.boost),
        .tick  (tick)
    );

    // ---------------- state register ----------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next-state logic ----------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (is_master && !mfault && wr_data) state_d = ST_M_FIRST;
                else if (is_slave && !ss_s)         state_d = ST_S_ACTIVE;
            end
            ST_M_FIRST: begin
                if (!is_master || mfault) state_d = ST_IDLE;
                else if (tick)            state_d = ST_M_SECOND;
            end
            ST_M_SECOND: begin
                if (!is_master || mfault) state_d = ST_IDLE;
                else if (tick)            state_d = (bit_cnt_q == LAST) ? ST_IDLE : ST_M_FIRST;
            end
            ST_S_ACTIVE: begin
                if (!is_slave || ss_s) state_d = ST_IDLE;
            end
        endcase
    end

    // ---------------- edge events ---------------------------------------------
    always_comb begin
        m_lead    = (state_q == ST_M_FIRST)  && tick && is_master && !mfault;
        m_trail   = (state_q == ST_M_SECOND) && tick && is_master && !mfault;
        s_edge    = (state_q == ST_S_ACTIVE) && is_slave && !ss_s && (sck_s != sck_prev_q);
        s_lead    = s_edge && (sck_s != cpol);
        s_trail   = s_edge && (sck_s == cpol);
        lead_ev   = m_lead || s_lead;
        trail_ev  = m_trail || s_trail;
        sample_ev = cpha ? trail_ev : lead_ev;
        setup_ev  = cpha ? lead_ev : trail_ev;
        // with late sampling the first bit is already on the line at the first setup edge
        do_shift  = setup_ev && (!cpha || nsamp_q != '0);
        flag_set  = sample_ev && (nsamp_q == LAST);
        load_tx   = wr_data && ((state_q == ST_IDLE) || is_slave);
        din       = is_master ? miso_i : mosi_s;
    end

    spi_shifter #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_tx),
        .load_val  (reg_wdata),
        .lsb_first (ctrl_q.lsb_first),
        .shift     (do_shift),
        .sample    (sample_ev),
        .din       (din),
        .dout      (tx_bit),
        .rx_next   (rx_next)
    );

    // ---------------- counters, clock and flag ----------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            nsamp_q    <= '0;
            sck_q      <= 1'b0;
            sck_prev_q <= 1'b0;
            done_flag  <= 1'b0;
            rx_buf_q   <= '0;
        end else begin
            sck_prev_q <= sck_s;

            if (state_q == ST_IDLE)  bit_cnt_q <= '0;
            else if (m_trail)        bit_cnt_q <= bit_cnt_q + CW'(1);

            if (state_q == ST_IDLE)  nsamp_q <= '0;
            else if (sample_ev)      nsamp_q <= (nsamp_q == LAST) ? '0 : nsamp_q + CW'(1);

            if (m_lead || m_trail)                                  sck_q <= ~sck_q;
            else if (state_q == ST_IDLE || state_q == ST_S_ACTIVE)  sck_q <= cpol;

            if (flag_set) begin
                done_flag <= 1'b1;
                rx_buf_q  <= rx_next;
            end else if (rd_data) begin
                done_flag <= 1'b0;
            end
        end
    end

    // ---------------- control word ------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= spi_ctrl_t'(reg_wdata[7:0]);
            if (mfault)  ctrl_q.master <= 1'b0;
        end
    end

    // ---------------- outputs ---------------------------------------------------
    always_comb begin
        sck_o     = sck_q;
        mosi_o    = is_master ? tx_bit : 1'b0;
        miso_oe   = is_slave && !ss_s;
        miso_o    = miso_oe ? tx_bit : 1'b0;
        reg_rdata = reg_addr ? rx_buf_q : DATA_W'(ctrl_q);
    end

    // ---------------- assertions ---------------------------------------------------
    // R11: a low select seen as enabled master drops the master bit next cycle
    assert_fault_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && ctrl_q.master && !ss_s && !wr_ctrl) |=> !ctrl_q.master);

    // R5: an idle engine with an unchanged mode rests SCK at the polarity bit
    assert_sck_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q == ST_IDLE) && $stable(ctrl_q.mode))
        |-> (sck_o == ctrl_q.mode[1]));

    // R3: a disabled engine never raises the flag
    assert_quiet_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |=> !$rose(done_flag));

    // R12: select high two cycles back keeps MISO released
    assert_miso_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ss_n_i) && $past(ss_n_i, 2)) |-> !miso_oe);

    // R10: a data read without a new completion leaves the flag clear
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !flag_set) |=> !done_flag);
endmodule

// File: tb/spi_engine_tb.sv
module spi_engine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       done_flag;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
    logic       sck_o, mosi_o, miso_o, miso_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    spi_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done_flag(done_flag), .sck_i(sck_i), .sck_o(sck_o), .mosi_i(mosi_i),
        .mosi_o(mosi_o), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n_i(ss_n_i)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic bit_at(input logic [7:0] b, input int k, input logic lsb);
        return lsb ? b[k] : b[7-k];
    endfunction

    function automatic int half_of(input logic [1:0] rate, input logic boost);
        int h;
        case (rate)
            2'd0: h = 2;
            2'd1: h = 8;
            2'd2: h = 32;
            default: h = 64;
        endcase
        return boost ? h / 2 : h;
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        rd(1'b0, d);
        check("R1 ctrl after reset", d, 8'h00);
        check("R1 flag after reset", done_flag, 0);
        check("R1 miso_oe after reset", miso_oe, 0);
        check("R1 sck after reset", sck_o, 0);
    endtask

    task automatic t_ctrl_rw();
        logic [7:0] d;
        wr(1'b0, 8'hAD);
        rd(1'b0, d);
        check("R2 ctrl readback AD", d, 8'hAD);
        wr(1'b0, 8'h5E);
        rd(1'b0, d);
        check("R2 ctrl readback 5E", d, 8'h5E);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_disabled();
        int moves = 0;
        logic s0;
        wr(1'b0, 8'h1C);          // master, mode 3, enable off
        repeat (2) @(negedge clk);
        s0 = sck_o;
        wr(1'b1, 8'h99);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (sck_o != s0) moves++;
        end
        check("R3 no SCK edge while disabled", moves, 0);
        check("R3 flag stays low while disabled", done_flag, 0);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_master(input logic [1:0] mode, input logic lsb, input logic [1:0] rate,
                            input logic boost, input logic [7:0] tx, input logic [7:0] rx,
                            input logic busy_wr);
        logic       cpol = mode[1];
        logic       cpha = mode[0];
        int         half = half_of(rate, boost);
        int         edges = 0, si = 0, last = 0, gap_bad = 0;
        logic       prev, cur, lead;
        logic [7:0] got = '0, d;
        wr(1'b0, {boost, 1'b1, lsb, 1'b1, mode, rate});
        repeat (2) @(negedge clk);
        check("R5 SCK rests before transfer", sck_o, cpol);
        miso_i = cpha ? 1'b0 : bit_at(rx, 0, lsb);
        wr(1'b1, tx);
        prev = sck_o;
        for (int cyc = 0; cyc < 5000 && edges < 16; cyc++) begin
            @(negedge clk);
            reg_wr = 1'b0;
            cur = sck_o;
            if (cur != prev) begin
                edges++;
                if (edges > 1 && (cyc - last) != half) gap_bad++;
                last = cyc;
                lead = (cur != cpol);
                if (lead != cpha) begin
                    if (lsb) got[si] = mosi_o; else got[7-si] = mosi_o;
                    si++;
                end else if (si < 8) begin
                    miso_i = bit_at(rx, si, lsb);
                end
                if (busy_wr && edges == 5) begin
                    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = ~tx;
                end
                prev = cur;
            end
        end
        reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 SCK edge count", edges, 16);
        check(boost ? "R9 boosted half-period" : "R8 half-period", gap_bad, 0);
        check("R4 R6 byte seen on MOSI", got, tx);
        check("R10 flag set after byte", done_flag, 1);
        rd(1'b1, d);
        check("R4 R6 byte captured from MISO", d, rx);
        check("R10 flag cleared by data read", done_flag, 0);
        check("R5 SCK rests after transfer", sck_o, cpol);
    endtask

    task automatic slave_bits(input logic cpol, input logic cpha, input logic lsb,
                              input logic [7:0] rx, input int nbits, output logic [7:0] got);
        got = '0;
        for (int k = 0; k < nbits; k++) begin
            if (!cpha) begin
                mosi_i = bit_at(rx, k, lsb);
                repeat (4) @(negedge clk);
                if (lsb) got[k] = miso_o; else got[7-k] = miso_o;
                sck_i = ~cpol;
                repeat (4) @(negedge clk);
                sck_i = cpol;
            end else begin
                sck_i = ~cpol;
                mosi_i = bit_at(rx, k, lsb);
                repeat (4) @(negedge clk);
                if (lsb) got[k] = miso_o; else got[7-k] = miso_o;
                sck_i = cpol;
                repeat (4) @(negedge clk);
            end
        end
    endtask

    task automatic t_slave(input logic [1:0] mode, input logic lsb, input logic [7:0] tx,
                           input logic [7:0] rx, input int abort_bits);
        logic       cpol = mode[1];
        logic       cpha = mode[0];
        logic [7:0] got, d;
        wr(1'b0, {1'b0, 1'b1, lsb, 1'b0, mode, 2'b00});
        sck_i = cpol; mosi_i = 1'b0;
        repeat (3) @(negedge clk);
        wr(1'b1, tx);
        check("R12 MISO released while SS high", miso_oe, 0);
        if (abort_bits > 0) begin
            ss_n_i = 1'b0;
            repeat (4) @(negedge clk);
            slave_bits(cpol, cpha, lsb, 8'hFF, abort_bits, got);
            ss_n_i = 1'b1;
            repeat (6) @(negedge clk);
            check("R12 cut-short byte raises no flag", done_flag, 0);
            wr(1'b1, tx);
        end
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R12 MISO driven while SS low", miso_oe, 1);
        slave_bits(cpol, cpha, lsb, rx, 8, got);
        repeat (6) @(negedge clk);
        check("R13 slave flag after byte", done_flag, 1);
        rd(1'b1, d);
        check("R13 slave byte received", d, rx);
        check("R13 slave byte sent", got, tx);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        check("R12 MISO released after SS high", miso_oe, 0);
    endtask

    task automatic t_fault();
        logic [7:0] d;
        wr(1'b0, 8'h50);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        rd(1'b0, d);
        check("R11 master bit cleared", d[4], 0);
        check("R11 enable bit kept", d[6], 1);
        check("R11 acting as slave drives MISO", miso_oe, 1);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        wr(1'b0, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=expired exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_ctrl_rw();
        t_disabled();
        t_master(2'b00, 1'b0, 2'd0, 1'b0, 8'hA5, 8'h3C, 1'b0);
        t_master(2'b01, 1'b1, 2'd1, 1'b0, 8'h81, 8'h7E, 1'b0);
        t_master(2'b10, 1'b0, 2'd0, 1'b1, 8'hC3, 8'h5A, 1'b1);
        t_master(2'b11, 1'b1, 2'd2, 1'b1, 8'h96, 8'hE1, 1'b0);
        t_master(2'b00, 1'b1, 2'd3, 1'b0, 8'hF0, 8'h0F, 1'b0);
        t_master(2'b11, 1'b0, 2'd1, 1'b1, 8'h12, 8'h34, 1'b1);
        t_master(2'b01, 1'b0, 2'd2, 1'b0, 8'h6B, 8'hD2, 1'b0);
        t_master(2'b10, 1'b1, 2'd3, 1'b1, 8'h2E, 8'hB9, 1'b0);
        t_slave(2'b00, 1'b0, 8'hA7, 8'h59, 0);
        t_slave(2'b01, 1'b1, 8'h3B, 8'hC4, 0);
        t_slave(2'b10, 1'b1, 8'h6D, 8'h92, 3);
        t_slave(2'b11, 1'b0, 8'hE8, 8'h17, 2);
        t_fault();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule